// File: doc/BRIEF.md
# Asynchronous pseudo-static RAM access controller

This controller sits between a synchronous host and a 2M x 16 pseudo-static RAM that has an asynchronous SRAM-style pin interface. The host hands it one request at a time on a valid/ready port. A request can be a read or a write. It covers either one word or a 16-word page, and a two-bit lane mask picks the low byte, the high byte or both. The controller produces the active-low chip select, output enable, write enable and byte-lane strobes, the 21-bit word address and the tri-state data controls. It times every phase by counting clock cycles, and each count is derived from a clock-period parameter.

The memory cells are DRAM-based. For that reason the controller holds off all traffic for the power-up wait after reset, and it never keeps chip select low longer than the hidden-refresh limit. A page request that would run past that limit is cut into segments, with chip select high between them. In a page, the upper 17 address bits stay fixed and the low four bits advance by one per word, wrapping inside the page. Write data is pulled one word at a time through a take pulse. Read data comes back one word per valid pulse.

Top module: `psram_ctrl`

## Requirements
- R1: After reset is released, `cmd_ready` stays low and chip select stays high for N_PWR = ceil(200 us / clock period) cycles. Requests offered during that wait are not taken.
- R2: While `rst` is high, every strobe output is high (inactive), `ps_dq_oe` is low and `cmd_ready` is low.
- R3: A single read holds chip select and output enable low and write enable high for exactly N_RC = ceil(70 ns / period) cycles. The lane strobes follow `cmd_be` (bit 0 selects the low lane, bit 1 the high lane). It returns one `rd_valid` pulse with the word at `cmd_addr`, and a lane not selected reads as zero.
- R4: A single write holds chip select and write enable low, with output enable high, for exactly N_WR = max(N_RC, ceil(50 ns / period)) cycles. It drives `wr_data` on the bus throughout, and it alters only the selected lanes of the addressed word.
- R5: A page request transfers 16 words. Address bits 20..4 do not change while chip select is low. The low four bits start at the requested value and advance by one, modulo 16. The first word of a segment takes N_RC (read) or N_WR (write) cycles, and every further word takes N_PC = ceil(25 ns / period) cycles. A read gives one `rd_valid` per word in address order, and a write gives one `wr_take` per word.
- R6: Chip select is never low for more than N_CE = floor(20 us / period) consecutive cycles. A page is split into segments of 1 + floor((N_CE - first-word cycles) / N_PC) words, and each new segment resumes at the next address with a full first-word time.
- R7: Between any two low periods, chip select stays high for at least N_GAP = max(1, ceil(15 ns / period)) cycles, and the data bus is not driven during that time.
- R8: Output enable is never low while write enable is low. `ps_dq_oe` is high only while chip select and write enable are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Controller idle and able to take a request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_page | input | 1 | 1 = 16-word page, 0 = single word |
| cmd_addr | input | 21 | Start word address |
| cmd_be | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte (must be nonzero) |
| wr_data | input | 16 | Write word currently offered by the host |
| wr_take | output | 1 | `wr_data` is latched at the end of this cycle; host then offers the next word |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` holds a read word |
| rd_data | output | 16 | Read word, unselected lanes zero |
| ps_cs_n | output | 1 | Memory chip select, active low |
| ps_oe_n | output | 1 | Memory output enable, active low |
| ps_we_n | output | 1 | Memory write enable, active low |
| ps_ub_n | output | 1 | High-lane strobe, active low |
| ps_lb_n | output | 1 | Low-lane strobe, active low |
| ps_addr | output | 21 | Memory word address |
| ps_dq_o | output | 16 | Data to drive onto the memory bus |
| ps_dq_oe | output | 1 | Drive enable for `ps_dq_o` |
| ps_dq_i | input | 16 | Data sampled from the memory bus |

## Verification
The bench runs a long seeded random mix of reads and writes against a behavioural memory. The mix covers single words and pages, all three lane masks and start offsets anywhere in a page, drawn from a few page addresses so that reads land on earlier writes. Byte-masked writes followed by word reads show whether the lanes are merged correctly. Pages that start in the middle of a page and pages at the top of the address space show whether the low-bit wrap stays inside the page. The chip-select limit is lowered far enough that every page splits, so each measured low period confirms both the per-word timing and the segment boundary. A request held during the power-up wait shows whether the controller takes it early.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int ADDR_W    = 21;
    localparam int DATA_W    = 16;
    localparam int PAGE_BITS = 4;

    typedef enum logic [1:0] {
        ST_PWR,
        ST_IDLE,
        ST_ACC,
        ST_GAP
    } ctl_state_e;

    typedef struct packed {
        logic              wr;
        logic              page;
        logic [1:0]        be;
        logic [ADDR_W-1:0] addr;
    } acc_req_t;

    // Smallest cycle count covering a minimum time.
    function automatic int ceil_cyc(int t_ps, int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    // Largest cycle count staying inside a maximum time.
    function automatic int floor_cyc(int t_ps, int clk_ps);
        return t_ps / clk_ps;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_pwrup_timer.sv
module psram_pwrup_timer #(
    parameter int N_PWR = 20000
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int W = $clog2(N_PWR + 1);
    localparam logic [W-1:0] LAST = W'(N_PWR - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);

endmodule

// File: rtl/psram_cs_guard.sv
module psram_cs_guard #(
    parameter int N_PC = 3,
    parameter int N_CE = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_low,
    output logic room
);
    localparam int RUN_W = $clog2(N_CE + 2);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(N_CE + 1);

    // Cycles chip select has been low before the current cycle.
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!cs_low) begin
            run_q <= '0;
        end else if (run_q != RUN_SAT) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Another page step fits if the current cycle plus one step stays in bound.
    assign room = (int'(run_q) + 1 + N_PC) <= N_CE;

    // R6
    cs_run_limit_chk: assert property (@(posedge clk) disable iff (rst)
        cs_low |-> (int'(run_q) < N_CE));

endmodule

// File: rtl/psram_rd_capture.sv
module psram_rd_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [1:0]    be,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    localparam int HALF = DW / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cap;
            if (cap) begin
                rd_data[HALF-1:0]  <= be[0] ? dq_in[HALF-1:0]  : '0;
                rd_data[DW-1:HALF] <= be[1] ? dq_in[DW-1:HALF] : '0;
            end
        end
    end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int CLK_PS     = 10000,
    parameter int T_RC_PS    = 70000,
    parameter int T_WP_PS    = 50000,
    parameter int T_PC_PS    = 25000,
    parameter int T_OHZ_PS   = 15000,
    parameter int T_PWRUP_PS = 200_000_000,
    parameter int T_CEMAX_PS = 20_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic              cmd_page,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_be,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ps_cs_n,
    output logic              ps_oe_n,
    output logic              ps_we_n,
    output logic              ps_ub_n,
    output logic              ps_lb_n,
    output logic [ADDR_W-1:0] ps_addr,
    output logic [DATA_W-1:0] ps_dq_o,
    output logic              ps_dq_oe,
    input  logic [DATA_W-1:0] ps_dq_i
);
    localparam int N_RC  = imax(1, ceil_cyc(T_RC_PS, CLK_PS));
    localparam int N_WR  = imax(N_RC, ceil_cyc(T_WP_PS, CLK_PS));
    localparam int N_PC  = imax(1, ceil_cyc(T_PC_PS, CLK_PS));
    localparam int N_GAP = imax(1, ceil_cyc(T_OHZ_PS, CLK_PS));
    localparam int N_PWR = imax(1, ceil_cyc(T_PWRUP_PS, CLK_PS));
    localparam int N_CE  = floor_cyc(T_CEMAX_PS, CLK_PS);
    localparam int CNT_W = $clog2(imax(imax(N_WR, N_GAP), N_PC) + 1);

    ctl_state_e           st_q;
    acc_req_t             req_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [PAGE_BITS-1:0] left_q;
    logic                 resume_q;
    logic [DATA_W-1:0]    wdat_q;

    logic pwr_done, room, cs_low;
    logic accept, acc_end, more, step, resume, cap;
    logic [CNT_W-1:0] first_cnt;

    psram_pwrup_timer #(.N_PWR(N_PWR)) u_pwr (
        .clk  (clk),
        .rst  (rst),
        .done (pwr_done)
    );

    psram_cs_guard #(.N_PC(N_PC), .N_CE(N_CE)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .cs_low (cs_low),
        .room   (room)
    );

    psram_rd_capture #(.DW(DATA_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .be       (req_q.be),
        .dq_in    (ps_dq_i),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign cmd_ready = (st_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign cs_low    = (st_q == ST_ACC);
    assign acc_end   = cs_low && (cnt_q == '0);
    assign more      = (left_q != '0);
    assign step      = acc_end && more && room;
    assign resume    = (st_q == ST_GAP) && (cnt_q == '0) && resume_q;
    assign cap       = acc_end && !req_q.wr;
    assign first_cnt = req_q.wr ? CNT_W'(N_WR - 1) : CNT_W'(N_RC - 1);
    assign wr_take   = (accept && cmd_write) || ((step || resume) && req_q.wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_PWR;
            req_q    <= '0;
            cnt_q    <= '0;
            left_q   <= '0;
            resume_q <= 1'b0;
            wdat_q   <= '0;
        end else begin
            unique case (st_q)
                ST_PWR: begin
                    if (pwr_done) st_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (accept) begin
                        req_q  <= '{wr: cmd_write, page: cmd_page, be: cmd_be, addr: cmd_addr};
                        wdat_q <= wr_data;
                        left_q <= cmd_page ? '1 : '0;
                        cnt_q  <= cmd_write ? CNT_W'(N_WR - 1) : CNT_W'(N_RC - 1);
                        st_q   <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (!more) begin
                        st_q     <= ST_GAP;
                        cnt_q    <= CNT_W'(N_GAP - 1);
                        resume_q <= 1'b0;
                    end else begin
                        req_q.addr[PAGE_BITS-1:0] <= req_q.addr[PAGE_BITS-1:0] + 1'b1;
                        left_q <= left_q - 1'b1;
                        if (room) begin
                            cnt_q <= CNT_W'(N_PC - 1);
                            if (req_q.wr) wdat_q <= wr_data;
                        end else begin
                            st_q     <= ST_GAP;
                            cnt_q    <= CNT_W'(N_GAP - 1);
                            resume_q <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (resume_q) begin
                        st_q     <= ST_ACC;
                        cnt_q    <= first_cnt;
                        resume_q <= 1'b0;
                        if (req_q.wr) wdat_q <= wr_data;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign ps_cs_n  = !cs_low;
    assign ps_we_n  = !(cs_low && req_q.wr);
    assign ps_oe_n  = !(cs_low && !req_q.wr);
    assign ps_lb_n  = !(cs_low && req_q.be[0]);
    assign ps_ub_n  = !(cs_low && req_q.be[1]);
    assign ps_addr  = req_q.addr;
    assign ps_dq_o  = wdat_q;
    assign ps_dq_oe = cs_low && req_q.wr;

    // R8
    no_oe_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        !ps_we_n |-> ps_oe_n);

    // R8
    drive_only_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        ps_dq_oe |-> (!ps_cs_n && !ps_we_n));

    // R5
    page_row_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (!ps_cs_n && $past(!ps_cs_n)) |-> $stable(ps_addr[ADDR_W-1:PAGE_BITS]));

    // R3
    rd_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!ps_cs_n && !ps_oe_n && ps_we_n));

    // R1
    no_early_ready_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> pwr_done);

endmodule

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb;
    localparam int CLK_NS  = 10;
    localparam int CE_PS   = 300_000;
    localparam int E_RC    = 7;
    localparam int E_WR    = 7;
    localparam int E_PC    = 3;
    localparam int E_GAP   = 2;
    localparam int E_PWR   = 20000;
    localparam int E_CE    = 30;
    localparam int E_WPS   = 1 + (E_CE - E_RC) / E_PC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic        cmd_page = 1'b0;
    logic [20:0] cmd_addr = '0;
    logic [1:0]  cmd_be = 2'b11;
    logic [15:0] wr_data;
    logic        wr_take, rd_valid;
    logic [15:0] rd_data;
    logic        ps_cs_n, ps_oe_n, ps_we_n, ps_ub_n, ps_lb_n, ps_dq_oe;
    logic [20:0] ps_addr;
    logic [15:0] ps_dq_o;
    logic [15:0] ps_dq_i = '0;

    always #(CLK_NS / 2) clk = ~clk;

    psram_ctrl #(.T_CEMAX_PS(CE_PS)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_page(cmd_page), .cmd_addr(cmd_addr),
        .cmd_be(cmd_be), .wr_data(wr_data), .wr_take(wr_take),
        .rd_valid(rd_valid), .rd_data(rd_data), .ps_cs_n(ps_cs_n),
        .ps_oe_n(ps_oe_n), .ps_we_n(ps_we_n), .ps_ub_n(ps_ub_n),
        .ps_lb_n(ps_lb_n), .ps_addr(ps_addr), .ps_dq_o(ps_dq_o),
        .ps_dq_oe(ps_dq_oe), .ps_dq_i(ps_dq_i)
    );

    int vectors = 0;
    int miscmp  = 0;
    bit done    = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory and bench reference.
    logic [15:0] mem  [int];
    logic [15:0] refm [int];

    function automatic logic [15:0] mget(int a);
        return mem.exists(a) ? mem[a] : 16'h0;
    endfunction

    function automatic logic [15:0] rget(int a);
        return refm.exists(a) ? refm[a] : 16'h0;
    endfunction

    function automatic logic [15:0] wfn(int n, int i);
        return 16'((n * 16'h3B5) ^ (i * 16'h1111) ^ 16'hA5C3);
    endfunction

    always @(negedge clk) begin
        if (!ps_cs_n && !ps_we_n) begin
            logic [15:0] o;
            o = mget(int'(ps_addr));
            if (!ps_lb_n) o[7:0]  = ps_dq_o[7:0];
            if (!ps_ub_n) o[15:8] = ps_dq_o[15:8];
            mem[int'(ps_addr)] = o;
        end
        ps_dq_i <= (!ps_cs_n && !ps_oe_n && ps_we_n) ? mget(int'(ps_addr)) : 16'h0;
    end

    // Current request seen by the monitor.
    bit          cur_wr, cur_pg;
    logic [1:0]  cur_be;
    int          rem, takes, rdcnt, widx;
    logic [15:0] wr_words [0:16];
    logic [15:0] exp_q [$];
    assign wr_data = wr_words[widx];

    int  low_run = 0, high_run = 0;
    bit  seen_low = 0;

    always @(negedge clk) begin
        if (!rst) begin
            // R8
            chk(!( !ps_we_n && !ps_oe_n) && !(ps_dq_oe && (ps_cs_n || ps_we_n)),
                "R8", "bus direction", {ps_we_n, ps_oe_n, ps_dq_oe}, 0);
            if (!ps_cs_n) begin
                if (low_run == 0 && seen_low) begin
                    // R7
                    chk(high_run >= E_GAP, "R7", "cs high gap", high_run, E_GAP);
                end
                seen_low = 1;
                high_run = 0;
                low_run++;
                chk(ps_lb_n == !cur_be[0] && ps_ub_n == !cur_be[1],
                    cur_wr ? "R4" : "R3", "lane strobes", {ps_ub_n, ps_lb_n}, {!cur_be[1], !cur_be[0]});
                if (!ps_we_n)
                    chk(ps_dq_oe == 1'b1, "R4", "bus driven in write", ps_dq_oe, 1);
            end else begin
                if (!ps_dq_oe == 1'b0)
                    chk(0, "R7", "bus driven with cs high", ps_dq_oe, 0);
                if (low_run > 0) begin
                    int w, e;
                    w = (rem < E_WPS) ? rem : E_WPS;
                    e = (cur_wr ? E_WR : E_RC) + (w - 1) * E_PC;
                    chk(low_run == e, cur_pg ? "R5" : (cur_wr ? "R4" : "R3"),
                        "cs low length", low_run, e);
                    // R6
                    chk(low_run <= E_CE, "R6", "cs low bound", low_run, E_CE);
                    rem -= w;
                    low_run = 0;
                end
                high_run++;
            end
            if (wr_take) takes++;
            if (rd_valid) begin
                logic [15:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hFFFF;
                rdcnt++;
                chk(rd_data == e, cur_pg ? "R5" : "R3", "read word", rd_data, e);
            end
        end
    end

    // Host write-data supplier: next word after each take.
    initial begin
        widx = 0;
        forever begin
            @(negedge clk);
            if (wr_take) begin
                @(posedge clk);
                #1 widx++;
            end
        end
    end

    int cmdno = 0;

    task automatic do_cmd(bit wr, bit pg, logic [20:0] a, logic [1:0] be);
        int n;
        n = pg ? 16 : 1;
        for (int i = 0; i < 17; i++) wr_words[i] = wfn(cmdno, i);
        for (int i = 0; i < n; i++) begin
            int ad;
            logic [15:0] o, d;
            ad = int'({a[20:4], 4'(a[3:0] + 4'(i))});
            o = rget(ad);
            d = wr_words[i];
            if (wr) refm[ad] = {be[1] ? d[15:8] : o[15:8], be[0] ? d[7:0] : o[7:0]};
            else    exp_q.push_back({be[1] ? o[15:8] : 8'h0, be[0] ? o[7:0] : 8'h0});
        end
        @(posedge clk);
        #1;
        while (!cmd_ready) begin @(posedge clk); #1; end
        cur_wr = wr; cur_pg = pg; cur_be = be;
        rem = n; takes = 0; rdcnt = 0; widx = 0;
        cmd_write = wr; cmd_page = pg; cmd_addr = a; cmd_be = be; cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        @(posedge clk);
        #1;
        while (!cmd_ready) begin @(posedge clk); #1; end
        if (wr) chk(takes == n, pg ? "R5" : "R4", "write takes", takes, n);
        else    chk(rdcnt == n && exp_q.size() == 0, pg ? "R5" : "R3", "read pulses", rdcnt, n);
        chk(rem == 0, "R6", "words covered by cs segments", rem, 0);
        cmdno++;
    endtask

    initial begin
        int pc;
        logic [20:0] pool [0:3];
        pool[0] = 21'h000000; pool[1] = 21'h1FFFF0; pool[2] = 21'h0A5A50; pool[3] = 21'h155550;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(posedge clk);
        #1;
        // R2
        chk(ps_cs_n && ps_oe_n && ps_we_n && ps_ub_n && ps_lb_n && !ps_dq_oe && !cmd_ready,
            "R2", "reset outputs", {ps_cs_n, ps_oe_n, ps_we_n, ps_ub_n, ps_lb_n, ps_dq_oe, cmd_ready}, 7'b1111100);
        rst = 1'b0;
        // R1: a request held early must not start an access.
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 21'h000123;
        pc = 0;
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
            if (pc == 100) cmd_valid = 1'b0;
            if (!ps_cs_n) chk(0, "R1", "cs low during power-up", pc, 0);
            pc++;
        end
        cmd_valid = 1'b0;
        chk(pc >= E_PWR && pc <= E_PWR + 1, "R1", "power-up cycles", pc, E_PWR);
        chk(mem.num() == 0, "R1", "memory untouched by early request", mem.num(), 0);

        // Directed corners.
        do_cmd(1, 0, 21'h000005, 2'b11);
        do_cmd(1, 0, 21'h000005, 2'b01);
        do_cmd(0, 0, 21'h000005, 2'b11);
        do_cmd(0, 0, 21'h000005, 2'b10);
        do_cmd(1, 1, 21'h1FFFF0, 2'b11);
        do_cmd(0, 1, 21'h1FFFFD, 2'b11);
        do_cmd(1, 1, 21'h0A5A57, 2'b10);
        do_cmd(0, 1, 21'h0A5A50, 2'b11);
        do_cmd(1, 0, 21'h1FFFFF, 2'b11);
        do_cmd(0, 0, 21'h1FFFFF, 2'b01);

        for (int k = 0; k < 150; k++) begin
            bit wr, pg;
            logic [1:0] be;
            logic [20:0] a;
            wr = 1'($urandom % 2);
            pg = ($urandom % 3) == 0;
            be = 2'($urandom % 3 + 1);
            a  = pool[$urandom % 4] | 21'($urandom % 16);
            do_cmd(wr, pg, a, be);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscmp++;
            vectors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

endmodule